// File: doc/BRIEF.md
# Four-Phase Strobe Transfer Engine

This block moves data words between two parties that share no transfer clock. Each side uses level strobes, and every strobe that enters the block passes through a two-flop synchronizer before any state machine acts on it. The block holds two cooperating halves. The initiator half starts a transfer. The responder half serves a transfer that a far-end initiator starts. The two halves can be wired to different peers, or back to back.

The initiator runs three operations. A push moves a word from the initiator to the peer: the initiator drives the word and raises a data-ready strobe. A pull fetches the peer's buffer word: the initiator raises a data-request strobe. A read cycle drives an address and raises a master-sync line; the peer answers on a slave-sync line, and the two lines step through a four-phase handshake in which each edge waits for the other party's last edge.

Pushes and pulls run in one of two modes, chosen at run time:
- **Acknowledged mode.** The initiator finishes only after it has seen the acknowledge line rise and then fall.
- **Strobe-only mode.** The initiator holds its strobe for a fixed window. It gets no confirmation of delivery, then waits a quiet gap of the same length.

A programmable stall limit aborts any handshake wait that runs too long and sets an error flag. The flag stays set until reset.

Top module: `hs_xfer_engine`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every strobe output, the acknowledge output, the slave-sync output, `done` and `err` are 0, and `ready` is 1.
- R2: An acknowledged push (`op`=0, `cfg_bidir`=1) drives `wdata` on `ini_dat_o` and raises `ini_rdy_o`. The responder stores the word in its buffer and raises `rsp_ack_o`. The initiator drops `ini_rdy_o` only after the acknowledge has arrived, and it pulses `done` for exactly one cycle once the acknowledge has fallen again.
- R3: A strobe-only push (`op`=0, `cfg_bidir`=0) holds `ini_rdy_o` for PULSE_CYC cycles and then pulses `done`. The responder stores the word and never raises `rsp_ack_o`.
- R4: An acknowledged pull (`op`=1, `cfg_bidir`=1) raises `ini_req_o`. The responder presents its buffer word on `rsp_dat_o` and raises `rsp_ack_o`. The initiator captures the word into `rx_data` when it sees the acknowledge, and drops `ini_req_o` only after that.
- R5: A strobe-only pull (`op`=1, `cfg_bidir`=0) holds `ini_req_o` for PULSE_CYC cycles and captures `ini_dat_i` into `rx_data` at the end of the window. No acknowledge is raised.
- R6: A read cycle (`op`=2, either mode) runs four phases, each waiting on the previous one:
  - the initiator drives `addr` on `ini_adr_o` and raises `ini_msy_o`;
  - the responder presents its buffer and raises `rsp_ssy_o`;
  - the initiator captures the word and drops `ini_msy_o`;
  - the responder releases the data and drops `rsp_ssy_o`.
  `done` pulses after the last phase.
- R7: A `start` is accepted only while `ready` is 1. `ready` is 1 only when the initiator is idle and both synchronized reply lines (acknowledge and slave-sync) are low. At most one of the three initiator strobes is high at any time. A `start` with `op`=3 does nothing.
- R8: If the initiator waits `cfg_tmo` cycles in one handshake phase without the expected reply edge, it drops all its strobes, returns to idle without a `done` pulse, and sets `err`. `err` stays 1 until reset. `cfg_tmo`=0 disables the limit.
- R9: `rsp_load` writes `rsp_load_data` into the responder buffer only while the responder is idle and no synchronized strobe is high. A captured push word wins over a load in the same cycle, and loads are ignored while a transfer is being served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_bidir | input | 1 | 1 = acknowledged mode, 0 = strobe-only mode |
| cfg_tmo | input | TMO_W | Stall limit in cycles; 0 disables it |
| start | input | 1 | Request to begin an initiator operation |
| op | input | 2 | 0 push, 1 pull, 2 read cycle, 3 none |
| addr | input | ADDR_W | Address for a read cycle |
| wdata | input | DATA_W | Word for a push |
| ready | output | 1 | Initiator can accept `start` |
| done | output | 1 | One-cycle pulse when an operation completes |
| err | output | 1 | Sticky stall-abort flag |
| rx_data | output | DATA_W | Last word captured by a pull or a read |
| ini_rdy_o | output | 1 | Data-ready strobe to the peer |
| ini_req_o | output | 1 | Data-request strobe to the peer |
| ini_msy_o | output | 1 | Master-sync line to the peer |
| ini_adr_o | output | ADDR_W | Address driven during a read cycle |
| ini_dat_o | output | DATA_W | Word driven during a push |
| ini_ack_i | input | 1 | Acknowledge from the peer (asynchronous) |
| ini_ssy_i | input | 1 | Slave-sync from the peer (asynchronous) |
| ini_dat_i | input | DATA_W | Word presented by the peer |
| rsp_rdy_i | input | 1 | Data-ready strobe from a far initiator |
| rsp_req_i | input | 1 | Data-request strobe from a far initiator |
| rsp_msy_i | input | 1 | Master-sync from a far initiator |
| rsp_dat_i | input | DATA_W | Word pushed by a far initiator |
| rsp_ack_o | output | 1 | Acknowledge to a far initiator |
| rsp_ssy_o | output | 1 | Slave-sync to a far initiator |
| rsp_dat_o | output | DATA_W | Buffer word presented to a far initiator |
| rsp_load | input | 1 | Local write of the responder buffer |
| rsp_load_data | input | DATA_W | Word for the local write |
| rsp_buf | output | DATA_W | Current responder buffer word |

## Verification
Two functions can land in the same cycle.

The first pair is a local buffer write on the responder and a pushed word being captured. The bench holds `rsp_load` high with a different word from before the push until the acknowledge shows up. The buffer must end up with the pushed word, not the local one.

The second pair is a new `start` and a transfer that is still in flight. The bench pulses `start` with another operation partway through a handshake, and also while the acknowledge line is forced high. It then judges that no second strobe appeared and that only one `done` pulse was counted.

// File: rtl/hs_pkg.sv
// Shared types for the strobe transfer engine.
package hs_pkg;

    // Operation codes; the encoding is visible on the top-level op port.
    typedef enum logic [1:0] {
        OP_SEND  = 2'd0,
        OP_FETCH = 2'd1,
        OP_READ  = 2'd2,
        OP_NONE  = 2'd3
    } xfer_op_e;

    // Initiator phases.
    typedef enum logic [2:0] {
        I_IDLE,
        I_PULSE,
        I_GAP,
        I_WAIT,
        I_REL
    } ini_st_e;

    // Responder phases.
    typedef enum logic {
        R_IDLE,
        R_HOLD
    } rsp_st_e;

endpackage

// File: rtl/hs_sync2.sv
// Two-flop synchronizer for a vector of independent level signals.
// Assumes each bit is a slow level that the receiver may see one cycle late;
// no multi-bit coherence is provided.
module hs_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta;

    // Two register stages, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/hs_initiator.sv
// Initiator half: starts pushes, pulls and interlocked read cycles.
// Assumes ack_s / ssy_s are already synchronized and that the data bus
// from the peer is stable whenever the matching reply line is seen high.
// PULSE_CYC must exceed the synchronizer depth plus one responder cycle.
module hs_initiator
    import hs_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 12,
    parameter int TMO_W     = 8,
    parameter int PULSE_CYC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_bidir,
    input  logic [TMO_W-1:0]  cfg_tmo,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack_s,
    input  logic              ssy_s,
    input  logic [DATA_W-1:0] rdat_i,
    output logic              ready,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rx_data,
    output logic              rdy_o,
    output logic              req_o,
    output logic              msy_o,
    output logic [ADDR_W-1:0] adr_o,
    output logic [DATA_W-1:0] dat_o
);

    localparam int CNT_W = $clog2(PULSE_CYC + 1);
    localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYC - 1);

    ini_st_e            st;
    xfer_op_e           cur_op;
    logic [CNT_W-1:0]   pcnt;
    logic [TMO_W-1:0]   tcnt;
    logic               reply;
    logic               tmo_hit;
    logic               go;
    xfer_op_e           op_in;

    // Decode the requested operation and the reply line that matters.
    always_comb begin
        op_in   = xfer_op_e'(op);
        reply   = (cur_op == OP_READ) ? ssy_s : ack_s;
        tmo_hit = (cfg_tmo != '0) && (tcnt >= cfg_tmo);
        ready   = (st == I_IDLE) && !ack_s && !ssy_s;
        go      = start && ready && (op_in != OP_NONE);
    end

    // Handshake sequencer with stall limit and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= I_IDLE;
            cur_op  <= OP_NONE;
            pcnt    <= '0;
            tcnt    <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
            rx_data <= '0;
            rdy_o   <= 1'b0;
            req_o   <= 1'b0;
            msy_o   <= 1'b0;
            adr_o   <= '0;
            dat_o   <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                I_IDLE: begin
                    if (go) begin
                        cur_op <= op_in;
                        tcnt   <= '0;
                        pcnt   <= PULSE_LAST;
                        case (op_in)
                            OP_SEND: begin
                                dat_o <= wdata;
                                rdy_o <= 1'b1;
                            end
                            OP_FETCH: req_o <= 1'b1;
                            default: begin
                                adr_o <= addr;
                                msy_o <= 1'b1;
                            end
                        endcase
                        st <= (op_in != OP_READ && !cfg_bidir) ? I_PULSE : I_WAIT;
                    end
                end
                I_PULSE: begin
                    if (pcnt == '0) begin
                        rdy_o <= 1'b0;
                        req_o <= 1'b0;
                        dat_o <= '0;
                        if (cur_op == OP_FETCH) rx_data <= rdat_i;
                        done  <= 1'b1;
                        pcnt  <= PULSE_LAST;
                        st    <= I_GAP;
                    end else begin
                        pcnt <= pcnt - 1'b1;
                    end
                end
                I_GAP: begin
                    if (pcnt == '0) st <= I_IDLE;
                    else            pcnt <= pcnt - 1'b1;
                end
                I_WAIT: begin
                    if (reply) begin
                        if (cur_op != OP_SEND) rx_data <= rdat_i;
                        rdy_o <= 1'b0;
                        req_o <= 1'b0;
                        msy_o <= 1'b0;
                        adr_o <= '0;
                        tcnt  <= '0;
                        st    <= I_REL;
                    end else if (tmo_hit) begin
                        rdy_o <= 1'b0;
                        req_o <= 1'b0;
                        msy_o <= 1'b0;
                        adr_o <= '0;
                        dat_o <= '0;
                        err   <= 1'b1;
                        st    <= I_IDLE;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                I_REL: begin
                    if (!reply) begin
                        done  <= 1'b1;
                        dat_o <= '0;
                        st    <= I_IDLE;
                    end else if (tmo_hit) begin
                        dat_o <= '0;
                        err   <= 1'b1;
                        st    <= I_IDLE;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                default: st <= I_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/hs_responder.sv
// Responder half: serves pushes, pulls and read cycles from a far initiator.
// Assumes the three strobes are synchronized and that a far initiator holds
// its data stable while its data-ready strobe is high. One buffer word.
module hs_responder
    import hs_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_bidir,
    input  logic              rdy_s,
    input  logic              req_s,
    input  logic              msy_s,
    input  logic [DATA_W-1:0] dat_i,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              ack_o,
    output logic              ssy_o,
    output logic [DATA_W-1:0] dat_o,
    output logic [DATA_W-1:0] buf_o
);

    rsp_st_e           st;
    xfer_op_e          sel;
    logic [DATA_W-1:0] bufr;
    logic              line_lo;

    // Pick the strobe whose release ends the current service.
    always_comb begin
        case (sel)
            OP_SEND:  line_lo = !rdy_s;
            OP_FETCH: line_lo = !req_s;
            default:  line_lo = !msy_s;
        endcase
    end

    // Serve one strobe at a time, hold replies until that strobe drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= R_IDLE;
            sel   <= OP_NONE;
            bufr  <= '0;
            ack_o <= 1'b0;
            ssy_o <= 1'b0;
            dat_o <= '0;
        end else begin
            case (st)
                R_IDLE: begin
                    if (msy_s) begin
                        dat_o <= bufr;
                        ssy_o <= 1'b1;
                        sel   <= OP_READ;
                        st    <= R_HOLD;
                    end else if (req_s) begin
                        dat_o <= bufr;
                        ack_o <= cfg_bidir;
                        sel   <= OP_FETCH;
                        st    <= R_HOLD;
                    end else if (rdy_s) begin
                        bufr  <= dat_i;
                        ack_o <= cfg_bidir;
                        sel   <= OP_SEND;
                        st    <= R_HOLD;
                    end else if (load) begin
                        bufr <= load_data;
                    end
                end
                default: begin
                    if (line_lo) begin
                        ack_o <= 1'b0;
                        ssy_o <= 1'b0;
                        dat_o <= '0;
                        st    <= R_IDLE;
                    end
                end
            endcase
        end
    end

    assign buf_o = bufr;

endmodule

// File: rtl/hs_xfer_engine.sv
// Top: initiator and responder halves behind their input synchronizers.
// Assumes every *_i strobe is asynchronous to clk; data buses are sampled
// only under the protection of a synchronized strobe or reply.
module hs_xfer_engine #(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 12,
    parameter int TMO_W     = 8,
    parameter int PULSE_CYC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_bidir,
    input  logic [TMO_W-1:0]  cfg_tmo,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ready,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rx_data,
    output logic              ini_rdy_o,
    output logic              ini_req_o,
    output logic              ini_msy_o,
    output logic [ADDR_W-1:0] ini_adr_o,
    output logic [DATA_W-1:0] ini_dat_o,
    input  logic              ini_ack_i,
    input  logic              ini_ssy_i,
    input  logic [DATA_W-1:0] ini_dat_i,
    input  logic              rsp_rdy_i,
    input  logic              rsp_req_i,
    input  logic              rsp_msy_i,
    input  logic [DATA_W-1:0] rsp_dat_i,
    output logic              rsp_ack_o,
    output logic              rsp_ssy_o,
    output logic [DATA_W-1:0] rsp_dat_o,
    input  logic              rsp_load,
    input  logic [DATA_W-1:0] rsp_load_data,
    output logic [DATA_W-1:0] rsp_buf
);

    logic [1:0] ini_rep_s;
    logic [2:0] rsp_stb_s;

    hs_sync2 #(.W(2)) u_sync_ini (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ini_ssy_i, ini_ack_i}),
        .q     (ini_rep_s)
    );

    hs_sync2 #(.W(3)) u_sync_rsp (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({rsp_msy_i, rsp_req_i, rsp_rdy_i}),
        .q     (rsp_stb_s)
    );

    hs_initiator #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .TMO_W     (TMO_W),
        .PULSE_CYC (PULSE_CYC)
    ) u_ini (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_bidir (cfg_bidir),
        .cfg_tmo   (cfg_tmo),
        .start     (start),
        .op        (op),
        .addr      (addr),
        .wdata     (wdata),
        .ack_s     (ini_rep_s[0]),
        .ssy_s     (ini_rep_s[1]),
        .rdat_i    (ini_dat_i),
        .ready     (ready),
        .done      (done),
        .err       (err),
        .rx_data   (rx_data),
        .rdy_o     (ini_rdy_o),
        .req_o     (ini_req_o),
        .msy_o     (ini_msy_o),
        .adr_o     (ini_adr_o),
        .dat_o     (ini_dat_o)
    );

    hs_responder #(
        .DATA_W (DATA_W)
    ) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_bidir (cfg_bidir),
        .rdy_s     (rsp_stb_s[0]),
        .req_s     (rsp_stb_s[1]),
        .msy_s     (rsp_stb_s[2]),
        .dat_i     (rsp_dat_i),
        .load      (rsp_load),
        .load_data (rsp_load_data),
        .ack_o     (rsp_ack_o),
        .ssy_o     (rsp_ssy_o),
        .dat_o     (rsp_dat_o),
        .buf_o     (rsp_buf)
    );

endmodule

// File: rtl/hs_xfer_chk.sv
// Protocol checker bound to hs_xfer_engine; observes ports only.
module hs_xfer_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_bidir,
    input logic done,
    input logic err,
    input logic ini_rdy_o,
    input logic ini_req_o,
    input logic ini_msy_o,
    input logic ini_ack_i,
    input logic ini_ssy_i,
    input logic rsp_msy_i,
    input logic rsp_ssy_o
);

    // R2: completion is a single-cycle pulse
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: acknowledged push drops data-ready only after the acknowledge
    a_r2_rdy_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ini_rdy_o) && cfg_bidir) |-> (err || $past(ini_ack_i)));

    // R4: acknowledged pull drops data-request only after the acknowledge
    a_r4_req_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ini_req_o) && cfg_bidir) |-> (err || $past(ini_ack_i)));

    // R6: master-sync falls only after slave-sync is high
    a_r6_msy_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ini_msy_o) |-> (err || $past(ini_ssy_i)));

    // R6: slave-sync rises only while master-sync is high
    a_r6_ssy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_ssy_o) |-> $past(rsp_msy_i));

    // R6: slave-sync falls only after master-sync is low
    a_r6_ssy_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rsp_ssy_o) |-> !$past(rsp_msy_i));

    // R7: never two initiator strobes at once
    a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ini_rdy_o, ini_req_o, ini_msy_o}));

    // R8: the error flag is sticky
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

endmodule

bind hs_xfer_engine hs_xfer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_bidir (cfg_bidir),
    .done      (done),
    .err       (err),
    .ini_rdy_o (ini_rdy_o),
    .ini_req_o (ini_req_o),
    .ini_msy_o (ini_msy_o),
    .ini_ack_i (ini_ack_i),
    .ini_ssy_i (ini_ssy_i),
    .rsp_msy_i (rsp_msy_i),
    .rsp_ssy_o (rsp_ssy_o)
);

// File: tb/sim_hs_xfer_engine.sv
// Directed bench: initiator wired back to the responder, with a bench-side
// cut on the reply lines and a force on the acknowledge line.
module sim_hs_xfer_engine;

    localparam int DW = 16;
    localparam int AW = 12;
    localparam int TW = 8;
    localparam int PC = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_bidir = 1'b1;
    logic [TW-1:0] cfg_tmo = 8'd20;
    logic          start = 1'b0;
    logic [1:0]    op = 2'd3;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          ready, done, err;
    logic [DW-1:0] rx_data;
    logic          ini_rdy_o, ini_req_o, ini_msy_o;
    logic [AW-1:0] ini_adr_o;
    logic [DW-1:0] ini_dat_o;
    logic          ini_ack_i, ini_ssy_i;
    logic [DW-1:0] ini_dat_i;
    logic          rsp_ack_o, rsp_ssy_o;
    logic [DW-1:0] rsp_dat_o;
    logic          rsp_load = 1'b0;
    logic [DW-1:0] rsp_load_data = '0;
    logic [DW-1:0] rsp_buf;
    logic          cut = 1'b0;
    logic          frc_ack = 1'b0;

    int errors = 0;
    int checks = 0;
    int done_cnt = 0;
    logic ack_seen = 1'b0, rdy_seen = 1'b0, req_seen = 1'b0, ssy_seen = 1'b0;
    logic order_bad = 1'b0;
    logic [AW-1:0] adr_seen = '0;
    logic pm = 1'b0, ps = 1'b0;

    assign ini_ack_i = (rsp_ack_o & ~cut) | frc_ack;
    assign ini_ssy_i = rsp_ssy_o & ~cut;
    assign ini_dat_i = rsp_dat_o;

    always #2.5 clk = ~clk;

    hs_xfer_engine #(.DATA_W(DW), .ADDR_W(AW), .TMO_W(TW), .PULSE_CYC(PC)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_bidir(cfg_bidir), .cfg_tmo(cfg_tmo),
        .start(start), .op(op), .addr(addr), .wdata(wdata),
        .ready(ready), .done(done), .err(err), .rx_data(rx_data),
        .ini_rdy_o(ini_rdy_o), .ini_req_o(ini_req_o), .ini_msy_o(ini_msy_o),
        .ini_adr_o(ini_adr_o), .ini_dat_o(ini_dat_o),
        .ini_ack_i(ini_ack_i), .ini_ssy_i(ini_ssy_i), .ini_dat_i(ini_dat_i),
        .rsp_rdy_i(ini_rdy_o), .rsp_req_i(ini_req_o), .rsp_msy_i(ini_msy_o),
        .rsp_dat_i(ini_dat_o), .rsp_ack_o(rsp_ack_o), .rsp_ssy_o(rsp_ssy_o),
        .rsp_dat_o(rsp_dat_o), .rsp_load(rsp_load),
        .rsp_load_data(rsp_load_data), .rsp_buf(rsp_buf)
    );

    // Observation monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (done) done_cnt <= done_cnt + 1;
        if (rsp_ack_o) ack_seen <= 1'b1;
        if (ini_rdy_o) rdy_seen <= 1'b1;
        if (ini_req_o) req_seen <= 1'b1;
        if (ini_msy_o && rsp_ssy_o) ssy_seen <= 1'b1;
        if (ini_msy_o) adr_seen <= ini_adr_o;
        if (pm && !ini_msy_o && !ps && !err) order_bad <= 1'b1;
        if (ps && !rsp_ssy_o && ini_msy_o) order_bad <= 1'b1;
        pm <= ini_msy_o;
        ps <= rsp_ssy_o;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clr_flags();
        ack_seen = 1'b0; rdy_seen = 1'b0; req_seen = 1'b0;
        ssy_seen = 1'b0; order_bad = 1'b0; adr_seen = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic issue(input logic [1:0] o, input logic [AW-1:0] a, input logic [DW-1:0] w);
        @(negedge clk);
        op = o; addr = a; wdata = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0; op = 2'd3;
    endtask

    task automatic wait_idle(input int maxc);
        for (int i = 0; i < maxc; i++) begin
            if (ready && !ini_rdy_o && !ini_req_o && !ini_msy_o && !rsp_ack_o && !rsp_ssy_o) break;
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 strobes", {ini_rdy_o, ini_req_o, ini_msy_o, rsp_ack_o, rsp_ssy_o}, 0);
        check("R1 flags", {done, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready", ready, 1);
    endtask

    task automatic t_send(input logic bidir, input logic [DW-1:0] w);
        int d0;
        cfg_bidir = bidir; clr_flags(); d0 = done_cnt;
        issue(2'd0, '0, w);
        wait_idle(80);
        check(bidir ? "R2 buffer" : "R3 buffer", rsp_buf, w);
        check(bidir ? "R2 ack seen" : "R3 no ack", ack_seen, bidir);
        check(bidir ? "R2 one done" : "R3 one done", done_cnt - d0, 1);
    endtask

    task automatic t_fetch(input logic bidir, input logic [DW-1:0] w);
        int d0;
        cfg_bidir = bidir; clr_flags(); d0 = done_cnt;
        @(negedge clk); rsp_load_data = w; rsp_load = 1'b1;
        @(negedge clk); rsp_load = 1'b0;
        issue(2'd1, '0, '0);
        wait_idle(80);
        check(bidir ? "R4 rx" : "R5 rx", rx_data, w);
        check(bidir ? "R4 ack seen" : "R5 no ack", ack_seen, bidir);
        check(bidir ? "R4 done" : "R5 done", done_cnt - d0, 1);
    endtask

    task automatic t_read(input logic bidir, input logic [AW-1:0] a, input logic [DW-1:0] w);
        int d0;
        cfg_bidir = bidir; clr_flags(); d0 = done_cnt;
        @(negedge clk); rsp_load_data = w; rsp_load = 1'b1;
        @(negedge clk); rsp_load = 1'b0;
        issue(2'd2, a, '0);
        wait_idle(80);
        check("R6 rx", rx_data, w);
        check("R6 addr", adr_seen, a);
        check("R6 slave-sync in phase", ssy_seen, 1);
        check("R6 order", order_bad, 0);
        check("R6 done", done_cnt - d0, 1);
    endtask

    task automatic t_busy_start();
        int d0;
        cfg_bidir = 1'b1; clr_flags(); d0 = done_cnt;
        issue(2'd0, '0, 16'h3C3C);
        repeat (2) @(negedge clk);
        issue(2'd1, '0, '0);
        wait_idle(80);
        repeat (20) @(negedge clk);
        check("R7 busy start ignored", req_seen, 0);
        check("R7 single done", done_cnt - d0, 1);
        check("R7 buffer", rsp_buf, 16'h3C3C);
    endtask

    task automatic t_ready_block();
        int d0;
        clr_flags(); d0 = done_cnt;
        frc_ack = 1'b1;
        repeat (4) @(negedge clk);
        check("R7 not ready", ready, 0);
        issue(2'd0, '0, 16'h1111);
        repeat (10) @(negedge clk);
        check("R7 blocked strobe", rdy_seen, 0);
        frc_ack = 1'b0;
        repeat (4) @(negedge clk);
        check("R7 ready again", ready, 1);
        check("R7 no done", done_cnt - d0, 0);
        issue(2'd3, '0, '0);
        repeat (4) @(negedge clk);
        check("R7 op3 no strobe", rdy_seen | req_seen, 0);
    endtask

    task automatic t_load_race();
        cfg_bidir = 1'b1; clr_flags();
        @(negedge clk); rsp_load_data = 16'hBEEF; rsp_load = 1'b1;
        issue(2'd0, '0, 16'hA5A5);
        for (int i = 0; i < 40; i++) begin
            if (rsp_ack_o) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
        rsp_load = 1'b0;
        wait_idle(80);
        check("R9 capture wins over load", rsp_buf, 16'hA5A5);
        @(negedge clk); rsp_load_data = 16'h0F0F; rsp_load = 1'b1;
        @(negedge clk); rsp_load = 1'b0;
        @(negedge clk);
        check("R9 idle load", rsp_buf, 16'h0F0F);
    endtask

    task automatic t_timeout();
        int d0;
        cfg_bidir = 1'b1; cfg_tmo = 8'd20; clr_flags(); d0 = done_cnt;
        cut = 1'b1;
        issue(2'd0, '0, 16'h7777);
        for (int i = 0; i < 100; i++) begin
            if (err) break;
            @(negedge clk);
        end
        check("R8 err set", err, 1);
        check("R8 strobe dropped", ini_rdy_o, 0);
        check("R8 no done", done_cnt - d0, 0);
        cut = 1'b0;
        wait_idle(80);
        t_send(1'b1, 16'h2468);
        check("R8 err sticky", err, 1);
        do_reset();
        @(negedge clk);
        check("R8 err cleared by reset", err, 0);
        cfg_tmo = '0; cut = 1'b1; d0 = done_cnt;
        issue(2'd0, '0, 16'h9999);
        repeat (120) @(negedge clk);
        check("R8 limit disabled", {err, ini_rdy_o}, 2'b01);
        cut = 1'b0;
        wait_idle(80);
        check("R8 late completion", done_cnt - d0, 1);
        cfg_tmo = 8'd20;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset_state();
        t_send(1'b1, 16'hC0DE);
        t_send(1'b0, 16'h5A5A);
        t_fetch(1'b1, 16'h1234);
        t_fetch(1'b0, 16'h4321);
        t_read(1'b1, 12'h0AB, 16'hFACE);
        t_read(1'b0, 12'h3C1, 16'h0BAD);
        t_busy_start();
        t_ready_block();
        t_load_race();
        t_timeout();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule